// File: doc/BRIEF.md
# Auxiliary Winding Sampler and Discharge Timer

This block watches the power switch gate of a flyback converter and, after each turn-off, captures a digitised auxiliary-winding sense voltage once the leakage ringing has died away but while the secondary diode still conducts. The captured word is the output-voltage readback used by the over- and under-voltage checks. The same turn-off edge starts a timer that stops when the sense voltage collapses by more than a set offset below the captured word. That collapse marks the end of diode conduction, and the timer value feeds the constant-current estimator.

The delay from turn-off to capture has two values. A pair of feedback band flags picks between them with hysteresis, and the choice is frozen at each turn-off. One result set is published per switching cycle, at the next gate turn-on, with a one-clock valid strobe. That set holds the captured word, the discharge time, the switching period and a flag for cycles in which conduction never ended.

Top module: `aux_sense_timer`

## Requirements
- R1: While reset is held, and after it is released, all outputs read zero and `smp_vld` stays low until the first publication.
- R2: The word captured in a cycle is the `vs_code` value present at the clock edge exactly B edges after the turn-off edge. The turn-off edge is the first edge at which `gate` reads 0 after reading 1. B is `BLANK_LONG` (18) in long mode and `BLANK_SHORT` (10) in short mode.
- R3: `fb_high`=1 selects long mode and `fb_low`=1 (with `fb_high`=0) selects short mode. With both low, the previous mode is kept. Reset selects long mode. The mode is latched at each turn-off edge for that cycle.
- R4: End of conduction is detected at an edge after the capture edge when the captured word minus `vs_code` is strictly greater than `ZC_OFS` (50). A difference of exactly `ZC_OFS` is not a detection.
- R5: `dis_cycles` equals the number of edges from the turn-off edge to the detection edge.
- R6: If no detection happens before the next turn-on edge, `dis_cycles` equals the off-time in edges and `ccm_flag` is 1. Otherwise `ccm_flag` is 0.
- R7: `per_cycles` equals the number of edges between the two turn-on edges that bound the published cycle.
- R8: Results are published at the turn-on edge that ends a cycle, with `smp_vld` high for exactly one clock. Between strobes all result outputs hold their values.
- R9: A cycle whose turn-on edge arrives at or before its capture edge is discarded. So is the first turn-on after reset. No strobe is raised and the outputs keep their previous values.
- R10: `dis_cycles` and `per_cycles` saturate at 2^CW-1 (4095) rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gate | input | 1 | Power switch gate command, 1 = on |
| fb_high | input | 1 | Feedback above upper band threshold |
| fb_low | input | 1 | Feedback below lower band threshold |
| vs_code | input | SW (10) | Digitised auxiliary sense voltage |
| smp_word | output | SW (10) | Captured sense word of the last published cycle |
| smp_vld | output | 1 | One-clock strobe marking new results |
| dis_cycles | output | CW (12) | Diode discharge time in clocks |
| per_cycles | output | CW (12) | Switching period in clocks |
| ccm_flag | output | 1 | Conduction did not end before turn-on |

## Verification
The sense input carries a small edge-dependent ripple, so capturing one edge early or late shows up as a wrong word. Using the wrong blanking mode does the same. A boundary pair of drops, exactly at the offset and one code above it, catches a comparator written as greater-or-equal. That error would report early detection where continuous conduction is expected. Turn-on landing exactly on the capture edge, and one edge later, exposes an off-by-one in the discard rule that would publish stale or missing samples. One very long off-time catches counters that wrap instead of saturating, which would report tiny discharge times and periods.

// File: rtl/aux_sense_timer.sv
module aux_sense_timer #(
  parameter int SW          = 10,
  parameter int CW          = 12,
  parameter int BLANK_LONG  = 18,
  parameter int BLANK_SHORT = 10,
  parameter int ZC_OFS      = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate,
  input  logic          fb_high,
  input  logic          fb_low,
  input  logic [SW-1:0] vs_code,
  output logic [SW-1:0] smp_word,
  output logic          smp_vld,
  output logic [CW-1:0] dis_cycles,
  output logic [CW-1:0] per_cycles,
  output logic          ccm_flag
);

  localparam logic [CW-1:0] BL_L = CW'(BLANK_LONG);
  localparam logic [CW-1:0] BL_S = CW'(BLANK_SHORT);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam int            BMIN = (BLANK_LONG < BLANK_SHORT) ? BLANK_LONG : BLANK_SHORT;

  typedef enum logic [1:0] {S_WAIT, S_BLANK, S_DISCH, S_DONE} st_t;

  st_t           st;
  logic          gate_q, long_sel;
  logic [CW-1:0] tmr, per, blen, dis_r;
  logic [SW-1:0] hold;

  wire rise = gate & ~gate_q;
  wire fall = ~gate & gate_q;
  wire [SW:0] vs_plus = {1'b0, vs_code} + (SW+1)'(ZC_OFS);
  wire zc = {1'b0, hold} > vs_plus;
  wire pub = (st == S_DISCH) || (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_WAIT;
      gate_q <= 1'b0;
      long_sel <= 1'b1;
      tmr <= '0;
      per <= '0;
      blen <= BL_L;
      dis_r <= '0;
      hold <= '0;
      smp_word <= '0;
      smp_vld <= 1'b0;
      dis_cycles <= '0;
      per_cycles <= '0;
      ccm_flag <= 1'b0;
    end else begin
      gate_q <= gate;
      smp_vld <= 1'b0;
      if (fb_high) long_sel <= 1'b1;
      else if (fb_low) long_sel <= 1'b0;
      if (per != CMAX) per <= per + 1'b1;
      if (tmr != CMAX) tmr <= tmr + 1'b1;
      if (rise) begin
        per <= CW'(1);
        st <= S_WAIT;
        if (pub) begin
          smp_vld <= 1'b1;
          smp_word <= hold;
          per_cycles <= per;
          dis_cycles <= (st == S_DONE) ? dis_r : tmr;
          ccm_flag <= (st == S_DISCH);
        end
      end else if (fall) begin
        st <= S_BLANK;
        tmr <= CW'(1);
        blen <= long_sel ? BL_L : BL_S;
      end else begin
        case (st)
          S_BLANK: if (tmr == blen) begin
            hold <= vs_code;
            st <= S_DISCH;
          end
          S_DISCH: if (zc) begin
            dis_r <= tmr;
            st <= S_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> !smp_vld); // R8
  AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |-> $stable(smp_word) && $stable(dis_cycles) && $stable(per_cycles)); // R8
  AST_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!fb_high && !fb_low) |=> $stable(long_sel)); // R3
  AST_MODE_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    fb_high |=> long_sel); // R3
  AST_DIS_AFTER_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |-> dis_cycles > CW'(BMIN)); // R5
  AST_DIS_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |-> dis_cycles <= per_cycles); // R7

endmodule

// File: tb/aux_sense_timer_test.sv
module aux_sense_timer_test;
  localparam int CLK_NS = 10;
  localparam int BL = 18, BS = 10, OFS = 50, SAT = 4095;

  logic clk = 1'b0, rst_n = 1'b0, gate = 1'b0, fb_high = 1'b0, fb_low = 1'b0;
  logic [9:0] vs_code = '0;
  logic [9:0] smp_word;
  logic smp_vld, ccm_flag;
  logic [11:0] dis_cycles, per_cycles;

  aux_sense_timer uut (
    .clk(clk), .rst_n(rst_n), .gate(gate), .fb_high(fb_high), .fb_low(fb_low),
    .vs_code(vs_code), .smp_word(smp_word), .smp_vld(smp_vld),
    .dis_cycles(dis_cycles), .per_cycles(per_cycles), .ccm_flag(ccm_flag));

  always #(CLK_NS/2) clk = ~clk;

  int total = 0, bad = 0;
  bit model_long = 1'b1;
  bit exp_pub = 1'b0;
  int exp_word = 0, exp_dis = 0, exp_per = 0, exp_ccm = 0;
  int last_word = 0, last_dis = 0, last_per = 0, last_ccm = 0;
  int c_base = 0, c_drop_at = 0, c_drop = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  function automatic int vs_at(input int j);
    return (j < c_drop_at) ? c_base + (j % 5) : c_base - c_drop;
  endfunction

  function automatic int sat(input int v);
    return (v > SAT) ? SAT : v;
  endfunction

  task automatic check_pub();
    if (exp_pub) begin
      chk(smp_vld == 1'b1, "R8 strobe", smp_vld, 1);
      chk(smp_word == exp_word, "R2 word", smp_word, exp_word);
      chk(dis_cycles == exp_dis, "R5 dis", dis_cycles, exp_dis);
      chk(ccm_flag == exp_ccm, "R6 ccm", ccm_flag, exp_ccm);
      chk(per_cycles == exp_per, "R7 per", per_cycles, exp_per);
      last_word = exp_word; last_dis = exp_dis; last_per = exp_per; last_ccm = exp_ccm;
    end else begin
      chk(smp_vld == 1'b0, "R9 no strobe", smp_vld, 0);
      chk(smp_word == last_word && dis_cycles == last_dis, "R9 word kept", smp_word, last_word);
      chk(per_cycles == last_per && ccm_flag == last_ccm, "R9 per kept", per_cycles, last_per);
    end
  endtask

  task automatic cycle(input int on, input int off, input int base, input int drop_at,
                       input int drop, input bit fbh, input bit fbl);
    int b, z;
    if (fbh) model_long = 1'b1;
    else if (fbl) model_long = 1'b0;
    b = model_long ? BL : BS;
    for (int i = 0; i < on + off; i++) begin
      @(negedge clk);
      if (i == 1) check_pub();
      if (i == 2) chk(smp_vld == 1'b0, "R8 one clock", smp_vld, 0);
      if (i == 0) begin
        fb_high = fbh; fb_low = fbl;
        c_base = base; c_drop_at = drop_at; c_drop = drop;
      end
      if (i < on) begin
        gate = 1'b1; vs_code = 10'(base);
      end else begin
        gate = 1'b0; vs_code = 10'(vs_at(i - on));
      end
    end
    exp_pub = (off > b);
    exp_per = sat(on + off);
    exp_word = vs_at(b);
    z = -1;
    for (int j = b + 1; j < off && z < 0; j++)
      if (exp_word - vs_at(j) > OFS) z = j;
    if (z >= 0) begin exp_dis = sat(z); exp_ccm = 0; end
    else begin exp_dis = sat(off); exp_ccm = 1; end
  endtask

  initial begin
    #(CLK_NS * 200000);
    bad++; total++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    chk(smp_vld == 0 && smp_word == 0, "R1 reset word", smp_word, 0);
    chk(dis_cycles == 0 && per_cycles == 0 && ccm_flag == 0, "R1 reset counts", dis_cycles, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(smp_vld == 0 && per_cycles == 0, "R1 after release", smp_vld, 0);

    cycle(10, 60, 500, 30, 100, 0, 0);  // R9 first turn-on discarded; R3 reset long
    cycle(8, 60, 500, 30, 100, 0, 0);   // R2 long capture
    cycle(8, 60, 600, 25, 100, 0, 1);   // R3 short
    cycle(8, 60, 600, 25, 100, 0, 0);   // R3 keep short
    cycle(8, 60, 400, 40, 90, 1, 0);    // R3 back to long
    cycle(6, 70, 500, 30, 47, 0, 0);    // R4 exactly offset: no detection
    cycle(6, 70, 500, 30, 48, 0, 0);    // R4 one above offset
    cycle(6, 50, 700, 80, 100, 0, 1);   // R6 no detection before turn-on
    cycle(6, 10, 700, 5, 100, 0, 0);    // R9 turn-on on capture edge (short)
    cycle(6, 11, 700, 11, 100, 0, 0);   // R9 minimal published cycle
    cycle(6, 4200, 300, 5000, 0, 1, 0); // R10 saturation
    cycle(6, 40, 300, 30, 60, 0, 0);
    for (int k = 0; k < 60; k++) begin
      int on, off, base, da, dr;
      on = 3 + int'($urandom_range(37));
      off = 5 + int'($urandom_range(115));
      base = 200 + int'($urandom_range(700));
      da = int'($urandom_range(off + 10));
      dr = int'($urandom_range(120));
      cycle(on, off, base, da, dr, 1'($urandom_range(1)), 1'($urandom_range(1)));
    end
    cycle(5, 20, 500, 15, 80, 0, 0);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule